// File: doc/BRIEF.md
# Peripheral Clock and Access Disable Controller

This block holds one disable bit per peripheral in a bank of up to sixteen. A set bit turns off the clock enable and the register-access enable of its peripheral. A cleared bit turns them back on. A parameter mask records which peripherals this chip variant actually contains. An absent peripheral is never enabled, and its disable bit is tied to zero.

Software writes the disable word over a small configuration port and can read it back at any time. A change in the word does not reach the enables at once. It takes effect on the first instruction-cycle strobe edge that follows the write, so every change is delayed by one instruction cycle.

A gating path sits between the peripheral register bus and the peripherals. It passes write and read strobes only to a selected peripheral that is currently enabled. A read aimed at a disabled, absent or out-of-range peripheral returns zero and raises an invalid flag.

Top module: `pmcd_top`

## Requirements
- R1: After reset every disable bit reads zero and both `clk_en` and `acc_en` equal the presence mask (for the defaults, 0xB7 with eight peripherals).
- R2: A write on the configuration port stores `cfg_wdata` bit i as the disable bit of peripheral i when that peripheral is present; bits of absent peripherals and bits at or above `N` read back zero, and writes to them are ignored.
- R3: The enables take the new disable word only at the first clock edge with `icyc_stb` high that comes strictly after the write edge. A strobe in the same edge as the write still applies the old word. Without a strobe, the enables do not change.
- R4: `clk_en[i]` and `acc_en[i]` are both high exactly when peripheral i is present and its effective disable bit is clear.
- R5: `pw_we[i]` equals `pb_we` when `pb_sel == i` and `acc_en[i]` is high. In every other case it is zero. `pr_re` follows the same rule with `pb_re`.
- R6: When `pb_re` is high and the selected peripheral is enabled, `pb_rdata` carries that peripheral's slice `prd_in[i*DW +: DW]` and `pb_rd_invalid` is low.
- R7: When `pb_re` is high and the selected peripheral is disabled or absent, or `pb_sel >= N`, `pb_rdata` is all zero and `pb_rd_invalid` is high. When `pb_re` is low, both are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| icyc_stb | input | 1 | One-clock strobe marking an instruction-cycle boundary |
| cfg_we | input | 1 | Write strobe for the disable word |
| cfg_wdata | input | 16 | Disable word to write, bit i for peripheral i |
| cfg_rdata | output | 16 | Stored disable word |
| pb_sel | input | 4 | Peripheral index targeted by the register bus |
| pb_we | input | 1 | Register bus write strobe |
| pb_re | input | 1 | Register bus read strobe |
| pb_rdata | output | DW | Gated read data back to the bus |
| pb_rd_invalid | output | 1 | Read hit a disabled, absent or unknown peripheral |
| pw_we | output | N | Per-peripheral gated write strobes |
| pr_re | output | N | Per-peripheral gated read strobes |
| prd_in | input | N*DW | Read data from all peripherals, packed by index |
| clk_en | output | N | Per-peripheral clock enable |
| acc_en | output | N | Per-peripheral register-access enable |

## Verification
The bench writes the disable word in the same cycle as a strobe and checks that the enables keep the old value until the next strobe. A design that forwarded the word straight through would switch one instruction cycle early. The bench also holds the strobe low for long stretches after a write, which catches a design that reacts with no strobe at all. Writes that set the bits of absent peripherals must read back zero and must never raise those enables, which catches a design that ignores the presence mask. Bus accesses go to enabled, disabled, absent and out-of-range indices, so a gate that leaks strobes or data from a blocked peripheral shows up at once.

// File: rtl/pmcd_pkg.sv
package pmcd_pkg;
  localparam int MAX_PERIPH = 16;
  localparam int SEL_W      = $clog2(MAX_PERIPH);
  typedef logic [MAX_PERIPH-1:0] pmask_t;
endpackage

// File: rtl/pmcd_disable_reg.sv
module pmcd_disable_reg
  import pmcd_pkg::*;
#(
  parameter int     N            = 8,
  parameter pmask_t PRESENT_MASK = 16'h00B7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [MAX_PERIPH-1:0] cfg_wdata,
  output logic [N-1:0]          dis_q
);
  localparam logic [N-1:0] PMASK = PRESENT_MASK[N-1:0];

  logic [N-1:0] dis_d;

  // Absent peripherals never latch a disable bit.
  always_comb begin
    dis_d = dis_q;
    if (cfg_we) dis_d = cfg_wdata[N-1:0] & PMASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dis_q <= '0;
    else        dis_q <= dis_d;
  end
endmodule

// File: rtl/pmcd_eff_stage.sv
module pmcd_eff_stage
  import pmcd_pkg::*;
#(
  parameter int     N            = 8,
  parameter pmask_t PRESENT_MASK = 16'h00B7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         icyc_stb,
  input  logic [N-1:0] dis_q,
  output logic [N-1:0] en_q
);
  localparam logic [N-1:0] PMASK = PRESENT_MASK[N-1:0];

  logic [N-1:0] en_d;

  // The enable follows the stored disable word only at an instruction-cycle strobe.
  always_comb begin
    en_d = en_q;
    if (icyc_stb) en_d = PMASK & ~dis_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= PMASK;
    else        en_q <= en_d;
  end
endmodule

// File: rtl/pmcd_bus_gate.sv
module pmcd_bus_gate
  import pmcd_pkg::*;
#(
  parameter int N  = 8,
  parameter int DW = 16
) (
  input  logic [SEL_W-1:0] pb_sel,
  input  logic             pb_we,
  input  logic             pb_re,
  input  logic [N-1:0]     acc_en,
  input  logic [N*DW-1:0]  prd_in,
  output logic [N-1:0]     pw_we,
  output logic [N-1:0]     pr_re,
  output logic [DW-1:0]    pb_rdata,
  output logic             pb_rd_invalid
);
  logic [N-1:0]  hit;
  logic          sel_ok;
  logic [DW-1:0] mux_data;

  for (genvar g = 0; g < N; g++) begin : g_port
    assign hit[g]   = (pb_sel == SEL_W'(g)) && acc_en[g];
    assign pw_we[g] = pb_we && hit[g];
    assign pr_re[g] = pb_re && hit[g];
  end

  always_comb begin
    sel_ok   = 1'b0;
    mux_data = '0;
    for (int i = 0; i < N; i++) begin
      if (hit[i]) begin
        sel_ok   = 1'b1;
        mux_data = prd_in[i*DW +: DW];
      end
    end
  end

  assign pb_rdata      = (pb_re && sel_ok) ? mux_data : '0;
  assign pb_rd_invalid = pb_re && !sel_ok;
endmodule

// File: rtl/pmcd_top.sv
module pmcd_top
  import pmcd_pkg::*;
#(
  parameter int     N            = 8,
  parameter int     DW           = 16,
  parameter pmask_t PRESENT_MASK = 16'h00B7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  icyc_stb,
  input  logic                  cfg_we,
  input  logic [MAX_PERIPH-1:0] cfg_wdata,
  output logic [MAX_PERIPH-1:0] cfg_rdata,
  input  logic [SEL_W-1:0]      pb_sel,
  input  logic                  pb_we,
  input  logic                  pb_re,
  output logic [DW-1:0]         pb_rdata,
  output logic                  pb_rd_invalid,
  output logic [N-1:0]          pw_we,
  output logic [N-1:0]          pr_re,
  input  logic [N*DW-1:0]       prd_in,
  output logic [N-1:0]          clk_en,
  output logic [N-1:0]          acc_en
);
  logic         rs_q1, rs_q2;
  logic [N-1:0] dis_q;
  logic [N-1:0] en_q;

  // Reset is asserted asynchronously and released on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q1 <= 1'b0;
      rs_q2 <= 1'b0;
    end else begin
      rs_q1 <= 1'b1;
      rs_q2 <= rs_q1;
    end
  end

  pmcd_disable_reg #(.N(N), .PRESENT_MASK(PRESENT_MASK)) u_reg (
    .clk(clk), .rst_n(rs_q2), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .dis_q(dis_q)
  );

  pmcd_eff_stage #(.N(N), .PRESENT_MASK(PRESENT_MASK)) u_eff (
    .clk(clk), .rst_n(rs_q2), .icyc_stb(icyc_stb), .dis_q(dis_q), .en_q(en_q)
  );

  pmcd_bus_gate #(.N(N), .DW(DW)) u_gate (
    .pb_sel(pb_sel), .pb_we(pb_we), .pb_re(pb_re), .acc_en(en_q), .prd_in(prd_in),
    .pw_we(pw_we), .pr_re(pr_re), .pb_rdata(pb_rdata), .pb_rd_invalid(pb_rd_invalid)
  );

  assign cfg_rdata = MAX_PERIPH'(dis_q);
  assign clk_en    = en_q;
  assign acc_en    = en_q;
endmodule

// File: rtl/pmcd_chk.sv
module pmcd_chk
  import pmcd_pkg::*;
#(
  parameter int     N            = 8,
  parameter int     DW           = 16,
  parameter pmask_t PRESENT_MASK = 16'h00B7
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  icyc_stb,
  input logic [MAX_PERIPH-1:0] cfg_rdata,
  input logic                  pb_re,
  input logic [DW-1:0]         pb_rdata,
  input logic                  pb_rd_invalid,
  input logic [N-1:0]          pw_we,
  input logic [N-1:0]          pr_re,
  input logic [N-1:0]          clk_en,
  input logic [N-1:0]          acc_en
);
  localparam logic [N-1:0]          PMASK = PRESENT_MASK[N-1:0];
  localparam logic [MAX_PERIPH-1:0] WMASK = MAX_PERIPH'(PMASK);

  a_r2_absent_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata & ~WMASK) == '0);

  a_r3_strobe_loads: assert property (@(posedge clk) disable iff (!rst_n)
    icyc_stb |=> clk_en == (PMASK & ~$past(cfg_rdata[N-1:0])));

  a_r3_hold_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !icyc_stb |=> $stable(clk_en));

  a_r4_absent_off: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en & ~PMASK) == '0);

  a_r5_write_gated: assert property (@(posedge clk) disable iff (!rst_n)
    ((pw_we | pr_re) & ~acc_en) == '0 && $onehot0(pw_we) && $onehot0(pr_re));

  a_r7_invalid_zero: assert property (@(posedge clk) disable iff (!rst_n)
    pb_rd_invalid |-> (pb_rdata == '0 && pb_re));
endmodule

bind pmcd_top pmcd_chk #(.N(N), .DW(DW), .PRESENT_MASK(PRESENT_MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .icyc_stb(icyc_stb), .cfg_rdata(cfg_rdata),
  .pb_re(pb_re), .pb_rdata(pb_rdata), .pb_rd_invalid(pb_rd_invalid),
  .pw_we(pw_we), .pr_re(pr_re), .clk_en(clk_en), .acc_en(acc_en)
);

// File: tb/sim_pmcd_top.sv
`timescale 1ns/1ps
module sim_pmcd_top;
  localparam int N = 8;
  localparam int DW = 16;
  localparam logic [15:0] PM = 16'h00B7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic icyc_stb = 1'b0, cfg_we = 1'b0, pb_we = 1'b0, pb_re = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic [3:0] pb_sel = '0;
  logic [DW-1:0] pb_rdata;
  logic pb_rd_invalid;
  logic [N-1:0] pw_we, pr_re, clk_en, acc_en;
  logic [N*DW-1:0] prd_in = '0;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [N-1:0] m_dis, m_en;

  always #5 clk = ~clk;

  pmcd_top #(.N(N), .DW(DW), .PRESENT_MASK(PM)) u0 (
    .clk(clk), .rst_n(rst_n), .icyc_stb(icyc_stb), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .pb_sel(pb_sel), .pb_we(pb_we), .pb_re(pb_re),
    .pb_rdata(pb_rdata), .pb_rd_invalid(pb_rd_invalid), .pw_we(pw_we), .pr_re(pr_re),
    .prd_in(prd_in), .clk_en(clk_en), .acc_en(acc_en)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] exp_gate(input logic en_bit_req, input logic [3:0] sel,
                                            input logic [N-1:0] en);
    logic [N-1:0] v = '0;
    if (en_bit_req && sel < 4'(N) && en[sel[2:0]]) v[sel[2:0]] = 1'b1;
    return v;
  endfunction

  function automatic logic [DW-1:0] exp_rdata(input logic re, input logic [3:0] sel,
                                              input logic [N-1:0] en, input logic [N*DW-1:0] d);
    if (re && sel < 4'(N) && en[sel[2:0]]) return d[sel[2:0]*DW +: DW];
    return '0;
  endfunction

  task automatic check_all();
    chk("R2 readback", 64'(cfg_rdata), 64'(m_dis));
    chk("R4 clk_en", 64'(clk_en), 64'(m_en));
    chk("R4 acc_en", 64'(acc_en), 64'(m_en));
    chk("R5 pw_we", 64'(pw_we), 64'(exp_gate(pb_we, pb_sel, m_en)));
    chk("R5 pr_re", 64'(pr_re), 64'(exp_gate(pb_re, pb_sel, m_en)));
    chk("R6 R7 rdata", 64'(pb_rdata), 64'(exp_rdata(pb_re, pb_sel, m_en, prd_in)));
    chk("R7 invalid", 64'(pb_rd_invalid),
        64'(pb_re && !(pb_sel < 4'(N) && m_en[pb_sel[2:0]])));
  endtask

  // Apply one cycle of stimulus, check combinational outputs, then advance the model.
  task automatic step(input logic we, input logic [15:0] wd, input logic stb,
                      input logic [3:0] sel, input logic bwe, input logic bre);
    cfg_we = we; cfg_wdata = wd; icyc_stb = stb;
    pb_sel = sel; pb_we = bwe; pb_re = bre;
    for (int i = 0; i < N; i++) prd_in[i*DW +: DW] = DW'($urandom);
    #1;
    check_all();
    @(posedge clk);
    if (stb) m_en = PM[N-1:0] & ~m_dis;
    if (we)  m_dis = wd[N-1:0] & PM[N-1:0];
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd1234));
    m_dis = '0;
    m_en  = PM[N-1:0];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 disable word", 64'(cfg_rdata), 64'h0);
    chk("R1 clk_en", 64'(clk_en), 64'(PM[N-1:0]));
    chk("R1 acc_en", 64'(acc_en), 64'(PM[N-1:0]));

    // R2 absent bits ignore writes
    step(1'b1, 16'hFFFF, 1'b0, 4'd0, 1'b0, 1'b0);
    chk("R2 absent bits zero", 64'(cfg_rdata), 64'(PM & 16'h00FF));
    // R3 no strobe -> no change for several cycles
    for (int k = 0; k < 5; k++) step(1'b0, 16'h0, 1'b0, 4'(k), 1'b1, 1'b1);
    chk("R3 hold without strobe", 64'(clk_en), 64'(PM[N-1:0]));
    step(1'b0, 16'h0, 1'b1, 4'd1, 1'b0, 1'b1);
    chk("R3 strobe applies", 64'(clk_en), 64'h0);
    // R7 reads of disabled, absent and out-of-range peripherals
    step(1'b0, 16'h0, 1'b0, 4'd3, 1'b1, 1'b1);
    step(1'b0, 16'h0, 1'b0, 4'd12, 1'b1, 1'b1);
    // R3 write coinciding with strobe: old word applied
    step(1'b1, 16'h0000, 1'b1, 4'd0, 1'b0, 1'b1);
    chk("R3 same-edge strobe keeps old", 64'(clk_en), 64'h0);
    step(1'b0, 16'h0, 1'b1, 4'd0, 1'b1, 1'b1);
    chk("R3 next strobe re-enables", 64'(clk_en), 64'(PM[N-1:0]));
    // R6 enabled read
    step(1'b0, 16'h0, 1'b0, 4'd7, 1'b1, 1'b1);

    // Constrained random mix
    for (int k = 0; k < 600; k++)
      step(($urandom % 4) == 0, 16'($urandom), ($urandom % 3) == 0, 4'($urandom % 11),
           ($urandom % 2) == 0, ($urandom % 2) == 0);

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule